// File: doc/BRIEF.md
# Snooping Write-Back Line Coherence Controller

This block tracks the coherence state of a single line in a private write-back cache that shares a snooping bus with other caches. The line is Invalid, Clean (a read-only copy other caches may also hold) or Dirty (the only copy, writable, newer than memory). The block serves two inputs. The first is the local processor, which presents a read or write to a block address. The second is the bus snoop port, which reports read misses, write misses and invalidates issued by other caches.

For the processor, the block decides whether the access can finish locally. If it cannot, the block raises a bus request with a command and holds it until the arbiter grants it. If a dirty block has to be evicted first, the block raises a write-back strobe and holds it until memory acknowledges. A snooped miss that hits the line while it is Dirty forces a write-back of that block before the line gives up ownership. State and tag change only when the grant or the acknowledge arrives.

Top module: `coh_line_ctrl`

## Requirements
- R1: During and right after reset the line reads Invalid (`line_state` encoding: 2'b00 Invalid, 2'b01 Clean, 2'b10 Dirty). In that state `bus_req`, `bus_wb` and `cpu_done` are low and `bus_cmd` is 2'b00.
- R2: A read whose address equals the tag of a Clean or Dirty line, and a write whose address equals the tag of a Dirty line, raise `cpu_done` in the same cycle with no bus request and no state change.
- R3: A read that misses on an Invalid or Clean line raises `bus_req` with `bus_cmd` 2'b01 and the address on `bus_addr`. These outputs stay stable until `bus_gnt`. In the grant cycle `cpu_done` is high, and from the next cycle the line is Clean with the new tag.
- R4: A write that misses on an Invalid or Clean line requests with `bus_cmd` 2'b10. On grant `cpu_done` is high, and the line becomes Dirty with the new tag.
- R5: A write whose address equals the tag of a Clean line requests with `bus_cmd` 2'b11. On grant `cpu_done` is high, and the line becomes Dirty.
- R6: A read or write that misses on a Dirty line first raises `bus_wb`, with the old tag on `bus_addr` and no `bus_req`, until `mem_ack`. The line is then Invalid and the miss of R3 or R4 follows.
- R7: A snooped write miss (2'b10) or invalidate (2'b11) whose address equals the tag of a Clean line makes it Invalid on the next cycle. A snooped read miss (2'b01) leaves a Clean line unchanged.
- R8: A snooped read miss, write miss or invalidate whose address equals the tag of a Dirty line raises `bus_wb` with that tag from the next cycle until `mem_ack`. Meanwhile the processor side is stalled. After the acknowledge the line is Clean if every such snoop was a read miss, and Invalid otherwise.
- R9: A snoop whose address differs from the tag, a snoop with command 2'b00, and any snoop on an Invalid line change nothing. A `bus_gnt` without `bus_req` and a `mem_ack` without `bus_wb` are also ignored.
- R10: In a cycle where a snoop matches the line, `cpu_done` stays low, even when the access would otherwise hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access pending, held until `cpu_done` |
| cpu_wr | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | TAG_W | Block address of the processor access |
| cpu_done | output | 1 | Access may proceed this cycle |
| bus_req | output | 1 | Request for the bus |
| bus_cmd | output | 2 | Requested command: 00 none, 01 read miss, 10 write miss, 11 invalidate |
| bus_addr | output | TAG_W | Block address of the request or write-back |
| bus_wb | output | 1 | Write-back of the dirty block in progress |
| bus_gnt | input | 1 | Arbiter grant for `bus_req` |
| mem_ack | input | 1 | Memory accepted the write-back |
| snoop_valid | input | 1 | Bus event from another cache |
| snoop_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snoop_addr | input | TAG_W | Snooped block address |
| line_state | output | 2 | Current line state |
| line_tag | output | TAG_W | Block address held by the line |

## Verification
The hardest case to reach is an overlap on a Dirty line. A snooped miss has to arrive while the processor's own eviction write-back is still waiting for memory, or a second snoop has to change the outcome of a write-back that a snoop already forced. The stimulus uses only four block addresses, injects snoops in about a quarter of the cycles and delays acknowledges at random. Both overlaps therefore occur many times, and a behavioural model compares every output on every cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV   = 2'b00,
    LS_CLEAN = 2'b01,
    LS_DIRTY = 2'b10
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_INVAL  = 2'b11
  } bus_cmd_e;

  // command a miss issues, by access direction
  function automatic bus_cmd_e miss_cmd(input logic wr);
    return wr ? BC_WRMISS : BC_RDMISS;
  endfunction

  // state a granted request commits to
  function automatic line_st_e grant_state(input bus_cmd_e c);
    return (c == BC_RDMISS) ? LS_CLEAN : LS_DIRTY;
  endfunction

  // snooped commands that take ownership away from this cache
  function automatic logic snoop_takes_line(input bus_cmd_e c);
    return (c == BC_WRMISS) || (c == BC_INVAL);
  endfunction

endpackage

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             snoop_valid,
  input  logic [1:0]       snoop_cmd,
  input  logic [TAG_W-1:0] snoop_addr,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             snoop_hit,
  output logic             snoop_kill
);
  bus_cmd_e cmd;
  assign cmd = bus_cmd_e'(snoop_cmd);

  // a snoop matters only if it carries a command and names our valid block
  assign snoop_hit  = snoop_valid && (cmd != BC_NONE) &&
                      (line_st != LS_INV) && (snoop_addr == line_tag);
  assign snoop_kill = snoop_hit && snoop_takes_line(cmd);
endmodule

// File: rtl/coh_cpu_unit.sv
module coh_cpu_unit
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             cpu_req,
  input  logic             cpu_wr,
  input  logic [TAG_W-1:0] cpu_addr,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  input  logic             wb_pend,
  output logic             local_done,
  output logic             cpu_wb,
  output bus_cmd_e         req_cmd
);
  logic tag_hit;
  assign tag_hit = (line_st != LS_INV) && (cpu_addr == line_tag);

  always_comb begin
    local_done = 1'b0;
    cpu_wb     = 1'b0;
    req_cmd    = BC_NONE;
    if (!wb_pend && cpu_req) begin
      if (tag_hit && (!cpu_wr || line_st == LS_DIRTY))
        local_done = 1'b1;
      else if (tag_hit)
        req_cmd = BC_INVAL;
      else if (line_st == LS_DIRTY)
        cpu_wb = 1'b1;
      else
        req_cmd = miss_cmd(cpu_wr);
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_wr,
  input  logic [TAG_W-1:0] cpu_addr,
  output logic             cpu_done,
  output logic             bus_req,
  output logic [1:0]       bus_cmd,
  output logic [TAG_W-1:0] bus_addr,
  output logic             bus_wb,
  input  logic             bus_gnt,
  input  logic             mem_ack,
  input  logic             snoop_valid,
  input  logic [1:0]       snoop_cmd,
  input  logic [TAG_W-1:0] snoop_addr,
  output logic [1:0]       line_state,
  output logic [TAG_W-1:0] line_tag
);
  line_st_e         st_q, tgt_q;
  logic [TAG_W-1:0] tag_q;
  logic             pend_q;

  // named internal events
  logic     snoop_hit, snoop_kill;
  logic     local_done, cpu_wb;
  bus_cmd_e req_cmd;
  logic     grant_ev, wb_done_ev;

  coh_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .line_st(st_q), .line_tag(tag_q),
    .snoop_hit(snoop_hit), .snoop_kill(snoop_kill)
  );

  coh_cpu_unit #(.TAG_W(TAG_W)) u_cpu (
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .line_st(st_q), .line_tag(tag_q), .wb_pend(pend_q),
    .local_done(local_done), .cpu_wb(cpu_wb), .req_cmd(req_cmd)
  );

  assign bus_req    = (req_cmd != BC_NONE);
  assign bus_cmd    = req_cmd;
  assign bus_wb     = pend_q || cpu_wb;
  assign bus_addr   = bus_wb ? tag_q : (bus_req ? cpu_addr : '0);
  assign grant_ev   = bus_req && bus_gnt;
  assign wb_done_ev = bus_wb && mem_ack;
  assign cpu_done   = !snoop_hit && (local_done || grant_ev);
  assign line_state = st_q;
  assign line_tag   = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= LS_INV;
      tgt_q  <= LS_INV;
      tag_q  <= '0;
      pend_q <= 1'b0;
    end else if (wb_done_ev) begin
      st_q   <= pend_q ? tgt_q : LS_INV;
      pend_q <= 1'b0;
    end else if (snoop_hit) begin
      if (st_q == LS_CLEAN) begin
        if (snoop_kill) st_q <= LS_INV;
      end else if (!pend_q) begin
        pend_q <= 1'b1;
        tgt_q  <= snoop_kill ? LS_INV : LS_CLEAN;
      end else if (snoop_kill) begin
        tgt_q <= LS_INV;
      end
    end else if (grant_ev) begin
      st_q  <= grant_state(req_cmd);
      tag_q <= cpu_addr;
    end
  end

  // R3: a waiting request does not move unless a snoop hits the line
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snoop_hit && cpu_req) |=>
      (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R3: a granted read miss leaves the line Clean
  assert_rdmiss_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_ev && !snoop_hit && bus_cmd == 2'b01) |=> (line_state == 2'b01));

  // R6: a write-back is held until memory acknowledges it
  assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wb && !mem_ack && cpu_req) |=> (bus_wb && $stable(bus_addr)));

  // R8: write-back and bus request never overlap, and the processor waits
  assert_wb_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wb |-> (!bus_req && !cpu_done));

  // R7: a taking snoop on a Clean line invalidates it
  assert_clean_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_state == 2'b01 && snoop_kill && !wb_done_ev) |=> (line_state == 2'b00));

  // R9: a non-matching snoop with no grant or acknowledge changes nothing
  assert_nomatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!snoop_hit && !grant_ev && !wb_done_ev) |=>
      ($stable(line_state) && $stable(line_tag)));

  // R10: a matching snoop blocks completion in its cycle
  assert_snoop_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit |-> !cpu_done);
endmodule

// File: tb/coh_line_ctrl_test.sv
module coh_line_ctrl_test;
  localparam int TAG_W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int CYCLES = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_wr = 1'b0;
  logic [TAG_W-1:0] cpu_addr = '0;
  logic cpu_done, bus_req, bus_wb;
  logic [1:0] bus_cmd, line_state;
  logic [TAG_W-1:0] bus_addr, line_tag;
  logic bus_gnt = 1'b0, mem_ack = 1'b0;
  logic snoop_valid = 1'b0;
  logic [1:0] snoop_cmd = 2'b00;
  logic [TAG_W-1:0] snoop_addr = '0;

  int checks = 0;
  int errors = 0;

  coh_line_ctrl #(.TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wb(bus_wb),
    .bus_gnt(bus_gnt), .mem_ack(mem_ack),
    .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_addr(snoop_addr),
    .line_state(line_state), .line_tag(line_tag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state: 0 Invalid, 1 Clean, 2 Dirty
  int m_st = 0, m_tgt = 0;
  int m_tag = 0;
  bit m_pend = 1'b0;
  // expected outputs of the current cycle
  bit e_req, e_wb, e_done;
  int e_cmd, e_addr;
  string lbl;

  task automatic expect_now();
    bit hit, local_ok, snh;
    hit = (m_st != 0) && (int'(cpu_addr) == m_tag);
    snh = snoop_valid && (snoop_cmd != 2'b00) && (m_st != 0) && (int'(snoop_addr) == m_tag);
    e_cmd = 0; e_wb = m_pend; local_ok = 1'b0;
    lbl = m_pend ? "R8" : "R9";
    if (!m_pend && cpu_req) begin
      if (hit && (!cpu_wr || m_st == 2)) begin local_ok = 1'b1; lbl = "R2"; end
      else if (hit) begin e_cmd = 3; lbl = "R5"; end
      else if (m_st == 2) begin e_wb = 1'b1; lbl = "R6"; end
      else begin e_cmd = cpu_wr ? 2 : 1; lbl = cpu_wr ? "R4" : "R3"; end
    end
    if (snh) lbl = (m_st == 1) ? "R7" : "R8";
    if (snh && local_ok) lbl = "R10";
    e_req = (e_cmd != 0);
    e_addr = e_wb ? m_tag : (e_req ? int'(cpu_addr) : 0);
    e_done = !snh && (local_ok || (e_req && bus_gnt));
  endtask

  task automatic model_step();
    bit snh;
    snh = snoop_valid && (snoop_cmd != 2'b00) && (m_st != 0) && (int'(snoop_addr) == m_tag);
    if (e_wb && mem_ack) begin
      m_st = m_pend ? m_tgt : 0;
      m_pend = 1'b0;
    end else if (snh) begin
      if (m_st == 1) begin
        if (snoop_cmd != 2'b01) m_st = 0;
      end else if (!m_pend) begin
        m_pend = 1'b1;
        m_tgt = (snoop_cmd == 2'b01) ? 1 : 0;
      end else if (snoop_cmd != 2'b01) begin
        m_tgt = 0;
      end
    end else if (e_req && bus_gnt) begin
      m_st = (e_cmd == 1) ? 1 : 2;
      m_tag = int'(cpu_addr);
    end
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check(lbl, "line_state", int'(line_state), m_st);
    check(lbl, "line_tag", int'(line_tag), m_tag);
    check(lbl, "bus_req", int'(bus_req), int'(e_req));
    check(lbl, "bus_cmd", int'(bus_cmd), e_cmd);
    check(lbl, "bus_wb", int'(bus_wb), int'(e_wb));
    check(lbl, "bus_addr", int'(bus_addr), e_addr);
    check(lbl, "cpu_done", int'(cpu_done), int'(e_done));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    bit prev_done;
    prev_done = 1'b1;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "line_state", int'(line_state), 0);
    check("R1", "bus_req", int'(bus_req), 0);
    check("R1", "bus_wb", int'(bus_wb), 0);
    check("R1", "bus_cmd", int'(bus_cmd), 0);
    check("R1", "cpu_done", int'(cpu_done), 0);
    rst_n = 1'b1;
    expect_now();
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      @(posedge clk);
      model_step();
      #1;
      if (prev_done || !cpu_req) begin
        cpu_req  = ($urandom_range(3) != 0);
        cpu_wr   = $urandom_range(1);
        cpu_addr = TAG_W'($urandom_range(3));
      end
      snoop_valid = ($urandom_range(3) == 0);
      snoop_cmd   = 2'($urandom_range(3));
      snoop_addr  = TAG_W'($urandom_range(3));
      bus_gnt = 1'b0; mem_ack = 1'b0;
      #1;
      if (!snoop_valid) begin
        bus_gnt = bus_req ? ($urandom_range(1) == 1) : ($urandom_range(9) == 0);
        mem_ack = bus_wb  ? ($urandom_range(2) == 0) : ($urandom_range(9) == 0);
      end
      expect_now();
      @(negedge clk);
      compare_all();
      prev_done = e_done;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule